// File: doc/BRIEF.md
# LPC Host Controller Register File

This block is the register file of an LPC host controller. It sits on a simple synchronous register bus: byte offset, byte enables, write enable, write data and combinational read data. It holds the firmware segment select word, the firmware read access size word, the serial interrupt control word, an interrupt mask, a write-one-to-clear interrupt status register and a read-only error address register.

Hardware raises status bits with one-cycle event pulses. Software reads the status register, then clears it by writing ones. A registered interrupt output reports whether any status bit is set while its mask bit is also set.

The read data follows the offset in the same cycle. A write takes effect at the next clock edge. Only full 32-bit accesses reach the registers. A partial access, and any offset that is not decoded, reads as all ones and changes nothing.

Top module: `lpc_hc_regs`

## Requirements
- R1: Out of reset, every register reads zero except the firmware read access size word, which reads 0x02000000 (the 4-byte code). The interrupt output is low.
- R2: The firmware segment select word (offset 0x24) and the firmware read access size word (offset 0x28) read back the full 32-bit value last written to them. The size codes are 0x00000000 for 1 byte, 0x01000000 for 2 bytes, 0x02000000 for 4 bytes, 0x04000000 for 16 bytes and 0x07000000 for 128 bytes.
- R3: The serial interrupt control word (offset 0x30) reads back the value written to it. Bit 31 is the enable and bit 30 selects quiet mode. Bits 25:24 give the start-frame width: 0 for 4 clocks, 1 for 6 clocks, 2 for 8 clocks.
- R4: A one-cycle pulse on bit n of `evt_set` sets status bit n, which reads as one at offset 0x38 from the next cycle. The implemented status bits are as follows, and all other status bits always read zero:
  - bits 31..15: serial interrupts 0..16 (bit 31 is interrupt 0);
  - bit 10: LPC reset;
  - bits 7..0, from bit 7 down: sync abnormal, no response, normal error, timeout, target turnaround, bus-master turnaround, bus-master 0 request, bus-master 1 request.
- R5: A write to the status register clears each bit that is one in the write data and leaves the bits written as zero unchanged.
- R6: When an event pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R7: The interrupt mask (offset 0x34) uses the status bit layout. Its unimplemented bits read zero.
- R8: `irq_o` is registered. In each cycle it equals the OR of (status AND mask) as it stood in the previous cycle.
- R9: The error address register (offset 0x40) ignores bus writes. It captures `err_addr_i` on a clock edge where `err_load` is high.
- R10: A read from any offset other than the six listed returns 0xFFFFFFFF. This includes misaligned offsets such as 0x25. A write to such an offset changes no register.
- R11: An access whose byte enables are not all ones (`bus_be` != 4'hF) is not a supported access. Its write changes no register and its read returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_be | input | 4 | Byte enables; only 4'hF is a supported access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset |
| evt_set | input | 32 | Per-bit one-cycle status set pulses |
| err_load | input | 1 | Load strobe for the error address register |
| err_addr_i | input | 32 | Error address value to capture |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The status register is driven in several ways:
- an all-ones event burst, which separates the implemented bits from the reserved ones;
- a sparse clear pattern, which shows that zero bits of the write data are left alone;
- a set and a clear landing on the same bit, which shows that the set takes priority.

The interrupt output is followed while the mask is opened and closed, which exposes its one-cycle lag.

The configuration words get distinct patterns and every access-size code. The remaining accesses show that nothing leaks through the decode:
- misaligned, unlisted and partial-width offsets;
- writes to the error address register.

// File: rtl/lpc_hc_pkg.sv
package lpc_hc_pkg;

    localparam int DATA_W = 32;

    localparam logic [31:0] OFS_SEG   = 32'h24;
    localparam logic [31:0] OFS_ACC   = 32'h28;
    localparam logic [31:0] OFS_SIRQ  = 32'h30;
    localparam logic [31:0] OFS_MASK  = 32'h34;
    localparam logic [31:0] OFS_STAT  = 32'h38;
    localparam logic [31:0] OFS_ERR   = 32'h40;

    localparam logic [DATA_W-1:0] ACC_RESET = 32'h0200_0000;

    // status layout: serial irqs 31..15, LPC reset 10, sync/bus-master 7..0
    localparam logic [DATA_W-1:0] STAT_SIRQ = 32'hFFFF_8000;
    localparam logic [DATA_W-1:0] STAT_LRST = 32'h0000_0400;
    localparam logic [DATA_W-1:0] STAT_SYNC = 32'h0000_00FF;
    localparam logic [DATA_W-1:0] STAT_IMPL = STAT_SIRQ | STAT_LRST | STAT_SYNC;

    typedef enum logic [2:0] {
        SEL_SEG,
        SEL_ACC,
        SEL_SIRQ,
        SEL_MASK,
        SEL_STAT,
        SEL_ERR,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] seg;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] sirq;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] err;
    } cfg_regs_t;

    function automatic reg_sel_e decode_ofs(input logic [31:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_SEG:  s = SEL_SEG;
            OFS_ACC:  s = SEL_ACC;
            OFS_SIRQ: s = SEL_SIRQ;
            OFS_MASK: s = SEL_MASK;
            OFS_STAT: s = SEL_STAT;
            OFS_ERR:  s = SEL_ERR;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lpc_hc_cfg.sv
module lpc_hc_cfg
    import lpc_hc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_sel_e          sel_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              err_load_i,
    input  logic [DATA_W-1:0] err_addr_i,
    output cfg_regs_t         cfg_o
);

    cfg_regs_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.seg  <= '0;
            cfg_q.acc  <= ACC_RESET;
            cfg_q.sirq <= '0;
            cfg_q.mask <= '0;
            cfg_q.err  <= '0;
        end else begin
            if (we_i) begin
                case (sel_i)
                    SEL_SEG:  cfg_q.seg  <= wdata_i;
                    SEL_ACC:  cfg_q.acc  <= wdata_i;
                    SEL_SIRQ: cfg_q.sirq <= wdata_i;
                    SEL_MASK: cfg_q.mask <= wdata_i & STAT_IMPL;
                    default:  ;
                endcase
            end
            if (err_load_i)
                cfg_q.err <= err_addr_i;
        end
    end

    assign cfg_o = cfg_q;

    // R9
    err_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && sel_i == SEL_ERR && !err_load_i) |=> $stable(cfg_q.err));

    // R2
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(we_i && sel_i == SEL_ACC) |=> $stable(cfg_q.acc));

endmodule

// File: rtl/lpc_hc_status.sv
module lpc_hc_status
    import lpc_hc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] evt_i,
    input  logic [DATA_W-1:0] clr_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] stat_o,
    output logic              irq_o
);

    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] set_v;
    logic              irq_q;

    assign set_v = evt_i & STAT_IMPL;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= (stat_q & ~clr_i) | set_v;
            irq_q  <= |(stat_q & mask_i);
        end
    end

    assign stat_o = stat_q;
    assign irq_o  = irq_q;

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((stat_q & $past(set_v)) == $past(set_v)));

    // R5
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((stat_q & $past(clr_i & ~set_v)) == '0));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past((stat_q & mask_i) == '0)) |-> !irq_o);

endmodule

// File: rtl/lpc_hc_rdmux.sv
module lpc_hc_rdmux
    import lpc_hc_pkg::*;
(
    input  reg_sel_e          sel_i,
    input  cfg_regs_t         cfg_i,
    input  logic [DATA_W-1:0] stat_i,
    output logic [DATA_W-1:0] rdata_o
);

    always_comb begin
        case (sel_i)
            SEL_SEG:  rdata_o = cfg_i.seg;
            SEL_ACC:  rdata_o = cfg_i.acc;
            SEL_SIRQ: rdata_o = cfg_i.sirq;
            SEL_MASK: rdata_o = cfg_i.mask;
            SEL_STAT: rdata_o = stat_i;
            SEL_ERR:  rdata_o = cfg_i.err;
            default:  rdata_o = '1;
        endcase
    end

endmodule

// File: rtl/lpc_hc_regs.sv
module lpc_hc_regs
    import lpc_hc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       evt_set,
    input  logic              err_load,
    input  logic [31:0]       err_addr_i,
    output logic              irq_o
);

    logic [31:0]       ofs_ext;
    logic              full_acc;
    reg_sel_e          sel;
    cfg_regs_t         cfg;
    logic [DATA_W-1:0] stat;
    logic [DATA_W-1:0] clr;

    assign ofs_ext  = 32'(bus_addr);
    assign full_acc = (bus_be == 4'hF);
    assign sel      = full_acc ? decode_ofs(ofs_ext) : SEL_NONE;
    assign clr      = (bus_we && sel == SEL_STAT) ? bus_wdata : '0;

    lpc_hc_cfg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .sel_i      (sel),
        .we_i       (bus_we),
        .wdata_i    (bus_wdata),
        .err_load_i (err_load),
        .err_addr_i (err_addr_i),
        .cfg_o      (cfg)
    );

    lpc_hc_status u_status (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt_set),
        .clr_i  (clr),
        .mask_i (cfg.mask),
        .stat_o (stat),
        .irq_o  (irq_o)
    );

    lpc_hc_rdmux u_rdmux (
        .sel_i   (sel),
        .cfg_i   (cfg),
        .stat_i  (stat),
        .rdata_o (bus_rdata)
    );

    // R11
    partial_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_be != 4'hF) |-> (bus_rdata == 32'hFFFF_FFFF));

endmodule

// File: tb/lpc_hc_regs_tb_top.sv
module lpc_hc_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] bus_addr;
    logic [3:0]  bus_be;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] evt_set;
    logic        err_load;
    logic [31:0] err_addr_i;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural model state
    logic [31:0] m_seg, m_acc, m_sirq, m_mask, m_stat, m_err;
    logic        m_irq;

    localparam logic [31:0] IMPL = 32'hFFFF_84FF;

    always #2 clk = ~clk;

    lpc_hc_regs dut_i (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_be     (bus_be),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .evt_set    (evt_set),
        .err_load   (err_load),
        .err_addr_i (err_addr_i),
        .irq_o      (irq_o)
    );

    function automatic logic [31:0] model_read(input logic [11:0] a, input logic [3:0] be);
        if (be != 4'hF) return 32'hFFFF_FFFF;
        case (a)
            12'h024: return m_seg;
            12'h028: return m_acc;
            12'h030: return m_sirq;
            12'h034: return m_mask;
            12'h038: return m_stat;
            12'h040: return m_err;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] a, input logic [3:0] be);
        if (be != 4'hF) return "R11";
        case (a)
            12'h024, 12'h028: return "R2";
            12'h030: return "R3";
            12'h034: return "R7";
            12'h038: return "R4";
            12'h040: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive at the falling edge, check read data, clock, check irq
    task automatic step(input logic [11:0] a, input logic [3:0] be, input logic we,
                        input logic [31:0] wd, input logic [31:0] ev,
                        input logic el, input logic [31:0] ea, input string tag);
        logic [31:0] clr;
        string t;
        bus_addr = a; bus_be = be; bus_we = we; bus_wdata = wd;
        evt_set = ev; err_load = el; err_addr_i = ea;
        #1;
        t = (tag == "") ? tag_of(a, be) : tag;
        check(t, bus_rdata, model_read(a, be));
        @(posedge clk);
        m_irq = |(m_stat & m_mask);
        clr = 32'h0;
        if (we && be == 4'hF) begin
            case (a)
                12'h024: m_seg  = wd;
                12'h028: m_acc  = wd;
                12'h030: m_sirq = wd;
                12'h034: m_mask = wd & IMPL;
                12'h038: clr    = wd;
                default: ;
            endcase
        end
        m_stat = (m_stat & ~clr) | (ev & IMPL);
        if (el) m_err = ea;
        @(negedge clk);
        check("R8", {31'h0, irq_o}, {31'h0, m_irq});
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        step(a, 4'hF, 1'b0, 32'h0, 32'h0, 1'b0, 32'h0, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(a, 4'hF, 1'b1, d, 32'h0, 1'b0, 32'h0, "");
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_addr = '0; bus_be = 4'hF; bus_we = 1'b0; bus_wdata = '0;
        evt_set = '0; err_load = 1'b0; err_addr_i = '0;
        m_seg = '0; m_acc = 32'h0200_0000; m_sirq = '0; m_mask = '0;
        m_stat = '0; m_err = '0; m_irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", {31'h0, irq_o}, 32'h0);

        // R1 reset values
        rd(12'h024, "R1"); rd(12'h028, "R1"); rd(12'h030, "R1");
        rd(12'h034, "R1"); rd(12'h038, "R1"); rd(12'h040, "R1");

        // R2 segment select and every access size code
        wr(12'h024, 32'hA5A5_0F0F); rd(12'h024, "R2");
        wr(12'h028, 32'h0000_0000); rd(12'h028, "R2");
        wr(12'h028, 32'h0100_0000); rd(12'h028, "R2");
        wr(12'h028, 32'h0400_0000); rd(12'h028, "R2");
        wr(12'h028, 32'h0700_0000); rd(12'h028, "R2");
        wr(12'h028, 32'h0200_0000); rd(12'h028, "R2");

        // R3 enable + quiet + 8-clock start, then 6-clock without enable
        wr(12'h030, 32'hC200_0000); rd(12'h030, "R3");
        wr(12'h030, 32'h4100_0000); rd(12'h030, "R3");

        // R7 mask keeps only implemented bits
        wr(12'h034, 32'hFFFF_FFFF); rd(12'h034, "R7");

        // R4 all-ones event burst, reserved bits stay zero; R8 irq follows
        step(12'h038, 4'hF, 1'b0, 32'h0, 32'hFFFF_FFFF, 1'b0, 32'h0, "R4");
        rd(12'h038, "R4");
        rd(12'h038, "R4");

        // R5 sparse clear: bits 15 and 10 drop, others remain
        step(12'h038, 4'hF, 1'b1, 32'h0000_FF00, 32'h0, 1'b0, 32'h0, "R5");
        rd(12'h038, "R5");

        // R6 set and clear on bit 7 in the same cycle
        step(12'h038, 4'hF, 1'b1, 32'h0000_00FF, 32'h0000_0080, 1'b0, 32'h0, "R6");
        rd(12'h038, "R6");

        // R8 closing the mask lowers irq one cycle later
        wr(12'h034, 32'h0);
        rd(12'h038, "R8");
        rd(12'h038, "R8");
        wr(12'h034, 32'h0000_0080);
        rd(12'h034, "R8");
        rd(12'h034, "R8");
        step(12'h038, 4'hF, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b0, 32'h0, "R5");
        rd(12'h038, "R8");
        rd(12'h038, "R8");

        // R9 error address ignores writes, loads from hardware
        wr(12'h040, 32'hDEAD_BEEF); rd(12'h040, "R9");
        step(12'h000, 4'hF, 1'b0, 32'h0, 32'h0, 1'b1, 32'h0000_1234, "R10");
        rd(12'h040, "R9");
        wr(12'h040, 32'h5555_5555); rd(12'h040, "R9");

        // R10 unlisted and misaligned offsets, write has no effect
        rd(12'h02C, "R10"); rd(12'h044, "R10"); rd(12'h025, "R10"); rd(12'hFFC, "R10");
        wr(12'h026, 32'h1111_1111); rd(12'h024, "R10");
        wr(12'h02C, 32'h2222_2222); rd(12'h028, "R10");

        // R11 partial byte enables
        step(12'h024, 4'h3, 1'b1, 32'h3333_3333, 32'h0, 1'b0, 32'h0, "R11");
        rd(12'h024, "R11");
        step(12'h034, 4'hE, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b0, 32'h0, "R11");
        rd(12'h034, "R11");
        step(12'h038, 4'h1, 1'b0, 32'h0, 32'h0, 1'b0, 32'h0, "R11");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule